// File: doc/BRIEF.md
# Accumulator ALU with Signed Shift

This block is the arithmetic core of a small accumulator-style datapath. It is purely combinational: two 16-bit operands and a 3-bit operation code go in, and in the same cycle it returns either a 16-bit result or a one-bit less-than flag. The surrounding datapath picks the operands and writes the result back. This block handles neither of those tasks.

The block supports bitwise AND and OR, modular add and subtract, one bidirectional shift, and a signed comparison. The shift direction comes from the sign of the second operand. A non-negative amount moves the first operand left. A negative amount moves it right, logically, by the magnitude. The comparison result does not use the result bus. It goes out on a dedicated flag, and the result bus reads zero for that operation.

Top module: `acc_alu`

## Requirements
- R1: With op_sel = 3'b000, result equals opnd_a AND opnd_b, bit by bit.
- R2: With op_sel = 3'b001, result equals opnd_a OR opnd_b, bit by bit.
- R3: With op_sel = 3'b010, result equals (opnd_a + opnd_b) modulo 2^16.
- R4: With op_sel = 3'b011, result equals (opnd_a - opnd_b) modulo 2^16.
- R5: With op_sel = 3'b100 and opnd_b read as two's complement in the range 0 to 15, result equals opnd_a shifted left by opnd_b, with zeros filled in. An amount of zero returns opnd_a unchanged.
- R6: With op_sel = 3'b100 and opnd_b in the range -1 to -15, result equals opnd_a shifted right logically (zero fill) by the magnitude of opnd_b.
- R7: With op_sel = 3'b100 and a shift magnitude of 16 or more in either direction (including opnd_b = 16'h8000), result is zero.
- R8: With op_sel = 3'b101, less_flag is 1 exactly when opnd_a < opnd_b as two's-complement numbers, and result is zero.
- R9: With op_sel = 3'b110 or 3'b111, result is zero and less_flag is zero.
- R10: less_flag is zero for every op_sel other than 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand, and the value being shifted |
| opnd_b | input | 16 | Second operand, and the signed shift amount |
| op_sel | input | 3 | Operation code |
| result | output | 16 | Result of the logic, arithmetic or shift operation |
| less_flag | output | 1 | Signed less-than outcome, valid only for op_sel = 3'b101 |

## Verification
The bench focuses on the shift boundary. It sweeps every amount from -17 to +17 and also applies 16'h8000. A shifter that takes only the low four bits of the amount would wrap at ±16 instead of clearing, and a negation that is one bit too narrow would turn -32768 into a left shift. The bench uses operands that straddle the sign bit, such as 16'h7FFF, 16'h8000 and 16'hFFFF. An unsigned comparator gives the wrong flag on these, and a right shift with sign fill would show ones in the top bits. The bench also checks that the flag stays low outside the compare operation and that the two reserved codes return zero. An incomplete decode would leak a neighbouring result onto the bus.

// File: rtl/acc_alu_pkg.sv
// Package: operation codes shared by the accumulator ALU and its checker.
// Assumes a 3-bit operation field; the encodings are fixed by the
// instruction decoder upstream and must not be reordered.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011,
        OP_SHF  = 3'b100,
        OP_SLT  = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } alu_op_e;

endpackage

// File: rtl/acc_alu_logic.sv
// Module: bitwise unit. Produces AND or OR of the operands.
// Assumes: sel_or chooses OR when high, AND otherwise.
module acc_alu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_or,
    output logic [W-1:0] y
);

    // Pick the bitwise combination requested.
    always_comb begin
        if (sel_or) y = a | b;
        else        y = a & b;
    end

endmodule

// File: rtl/acc_alu_addsub.sv
// Module: shared adder/subtractor. Subtraction is done as a plus the
// inverted b plus one, so only one carry chain is built.
// Assumes: results wrap modulo 2^W; no carry or overflow is reported.
module acc_alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;

    // Condition the second operand for subtraction.
    always_comb b_eff = b ^ {W{do_sub}};

    // Single carry chain with do_sub as the carry-in.
    always_comb y = a + b_eff + {{(W-1){1'b0}}, do_sub};

endmodule

// File: rtl/acc_alu_shift.sv
// Module: bidirectional shifter. Reads amt as two's complement: a
// non-negative amount shifts left, a negative one shifts right logically
// by its magnitude. A magnitude of W or more gives zero.
// Assumes: the magnitude is formed one bit wider than amt so that the
// most negative value does not wrap.
module acc_alu_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] amt,
    output logic [W-1:0] y
);

    localparam int MW  = W + 1;
    localparam int SAW = $clog2(W);

    logic          neg;
    logic [MW-1:0] amt_sx;
    logic [MW-1:0] mag;
    logic          too_far;
    logic [SAW-1:0] sa;

    // Sign-extend the amount and take its magnitude.
    always_comb begin
        neg    = amt[W-1];
        amt_sx = {amt[W-1], amt};
        mag    = neg ? (~amt_sx + MW'(1)) : amt_sx;
    end

    // Flag amounts that move every bit out of the word.
    always_comb too_far = (mag >= MW'(W));

    // Low bits of the magnitude drive the barrel.
    always_comb sa = mag[SAW-1:0];

    // Shift in the direction given by the sign, or clear the word.
    always_comb begin
        if (too_far)  y = '0;
        else if (neg) y = val >> sa;
        else          y = val << sa;
    end

endmodule

// File: rtl/acc_alu_cmp.sv
// Module: signed less-than comparator.
// Assumes: both operands are two's complement numbers of equal width.
module acc_alu_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt
);

    // Compare the operands as signed numbers.
    always_comb lt = ($signed(a) < $signed(b));

endmodule

// File: rtl/acc_alu.sv
// Module: top of the accumulator ALU. Runs every unit in parallel and
// steers the selected one to the outputs. The result bus reads zero for
// the compare and for the reserved codes. less_flag is gated so that it
// is high only during the compare.
// Assumes: purely combinational; the caller registers the outputs.
module acc_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         less_flag
);

    import acc_alu_pkg::*;

    alu_op_e      op;
    logic [W-1:0] logic_y;
    logic [W-1:0] arith_y;
    logic [W-1:0] shift_y;
    logic         lt_raw;

    // Type the raw operation code.
    always_comb op = alu_op_e'(op_sel);

    acc_alu_logic #(.W(W)) u_logic (
        .a      (opnd_a),
        .b      (opnd_b),
        .sel_or (op_sel[0]),
        .y      (logic_y)
    );

    acc_alu_addsub #(.W(W)) u_addsub (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (op_sel[0]),
        .y      (arith_y)
    );

    acc_alu_shift #(.W(W)) u_shift (
        .val (opnd_a),
        .amt (opnd_b),
        .y   (shift_y)
    );

    acc_alu_cmp #(.W(W)) u_cmp (
        .a  (opnd_a),
        .b  (opnd_b),
        .lt (lt_raw)
    );

    // Steer the chosen unit to the result bus.
    always_comb begin
        unique case (op)
            OP_AND, OP_OR:  result = logic_y;
            OP_ADD, OP_SUB: result = arith_y;
            OP_SHF:         result = shift_y;
            default:        result = '0;
        endcase
    end

    // Expose the comparison only for the compare code.
    always_comb less_flag = (op == OP_SLT) && lt_raw;

endmodule

// File: rtl/acc_alu_chk.sv
// Module: checker bound to acc_alu. Relates the ports with immediate
// assertions, because the block has no clock.
module acc_alu_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         less_flag
);

    // Check port relations whenever an input or output settles.
    always_comb begin
        if (op_sel == 3'b000) begin
            assert_and_subset_R1: assert ((result & ~opnd_a) == '0 && (result & ~opnd_b) == '0)
                else $error("AND result has bits outside an operand");
        end
        if (op_sel == 3'b001) begin
            assert_or_superset_R2: assert ((result & opnd_a) == opnd_a && (result & opnd_b) == opnd_b)
                else $error("OR result lost operand bits");
        end
        if (op_sel == 3'b010) begin
            assert_add_inverse_R3: assert (W'(result - opnd_b) == opnd_a)
                else $error("sum minus b does not return a");
        end
        if (op_sel == 3'b011) begin
            assert_sub_inverse_R4: assert (W'(result + opnd_b) == opnd_a)
                else $error("difference plus b does not return a");
        end
        if (op_sel == 3'b100 && opnd_b == '0) begin
            assert_shift_zero_R5: assert (result == opnd_a)
                else $error("zero shift changed the operand");
        end
        if (op_sel == 3'b100 && ($signed(opnd_b) >= W || $signed(opnd_b) <= -W)) begin
            assert_shift_clear_R7: assert (result == '0)
                else $error("oversized shift left bits behind");
        end
        if (op_sel == 3'b101) begin
            assert_slt_bus_zero_R8: assert (result == '0)
                else $error("compare drove the result bus");
            assert_slt_distinct_R8: assert (!less_flag || opnd_a != opnd_b)
                else $error("less-than reported for equal operands");
        end
        if (op_sel[2:1] == 2'b11) begin
            assert_reserved_zero_R9: assert (result == '0 && !less_flag)
                else $error("reserved code produced output");
        end
        if (op_sel != 3'b101) begin
            assert_flag_quiet_R10: assert (!less_flag)
                else $error("flag raised outside compare");
        end
    end

endmodule

bind acc_alu acc_alu_chk #(.W(W)) chk_i (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .less_flag (less_flag)
);

// File: tb/acc_alu_tb_top.sv
// Bench: sweeps every operation code across a fixed set of operands and
// every shift amount from -17 to +17. Expected values are computed here
// with integer arithmetic.
module acc_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic [15:0] result;
    logic        less_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    acc_alu #(.W(16)) dut_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_sel    (op_sel),
        .result    (result),
        .less_flag (less_flag)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] a_val(int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h8000;
            4: return 16'h7FFF;
            5: return 16'h00FF;
            6: return 16'hAAAA;
            7: return 16'h5555;
            default: return 16'((i * 40503 + 12345) ^ (i << 7));
        endcase
    endfunction

    function automatic logic [15:0] b_val(int j);
        if (j < 35) return 16'(j - 17);
        return a_val(j - 35);
    endfunction

    task automatic check16(string req, logic [15:0] got, logic [15:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: op=%b a=%h b=%h actual %h expected %h",
                     req, op_sel, opnd_a, opnd_b, got, exp);
        end
    endtask

    task automatic check1(string req, logic got, logic exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: op=%b a=%h b=%h flag actual %b expected %b",
                     req, op_sel, opnd_a, opnd_b, got, exp);
        end
    endtask

    // Apply one vector at a falling edge and check it 1 ns later.
    task automatic apply(logic [2:0] op, logic [15:0] a, logic [15:0] b);
        int sb;
        int av;
        int bv;
        logic [15:0] er;
        logic        ef;
        string       rq;
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #1;
        sb = int'($signed(b));
        av = int'($signed(a));
        bv = sb;
        er = '0;
        ef = 1'b0;
        case (op)
            3'b000: begin rq = "R1"; er = a & b; end
            3'b001: begin rq = "R2"; er = a | b; end
            3'b010: begin rq = "R3"; er = 16'(int'(a) + int'(b)); end
            3'b011: begin rq = "R4"; er = 16'(int'(a) - int'(b)); end
            3'b100: begin
                if (sb >= 16 || sb <= -16) begin rq = "R7"; er = '0; end
                else if (sb >= 0) begin rq = "R5"; er = 16'(int'(a) * (1 << sb)); end
                else begin rq = "R6"; er = 16'(int'(a) / (1 << (-sb))); end
            end
            3'b101: begin rq = "R8"; ef = (av < bv); er = '0; end
            default: begin rq = "R9"; end
        endcase
        check16(rq, result, er);
        check1((op == 3'b101) ? "R8" : (op[2:1] == 2'b11) ? "R9" : "R10", less_flag, ef);
    endtask

    initial begin
        // Reset phase: all-zero inputs give zero outputs (R1 AND of zeros).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check16("R1", result, 16'h0000);
        check1("R10", less_flag, 1'b0);
        rst_n = 1'b1;

        // Directed corners: shift by -32768 clears the word (R7), and a
        // sign-straddling compare (R8).
        apply(3'b100, 16'hFFFF, 16'h8000);
        apply(3'b100, 16'h8001, 16'hFFFF);
        apply(3'b101, 16'h8000, 16'h7FFF);
        apply(3'b101, 16'h7FFF, 16'h8000);

        // Sweep of every operation code over the operand sets.
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 32; i++) begin
                for (int j = 0; j < 64; j++) begin
                    apply(3'(op), a_val(i), b_val(j));
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule